// File: doc/BRIEF.md
# MAC Address Table Access Engine

This block gives a host processor a small mailbox of byte registers through which it can look up, add, fetch and remove entries in two on-chip switch address tables. One table holds unicast stations, each with an egress port number. The other holds multicast groups, each with a bitmap of member ports. Every entry also carries three attribute bits.

The host loads a 48-bit key into the six data bytes, or an entry index when it fetches by position. It puts payload bits in the port/attribute byte and then writes a command byte that names both the operation and the table. A busy flag stays high while the sequencer works. Lookups and inserts walk the table one entry per clock. When busy falls, the host reads a two-bit result code. After a successful lookup or fetch, the engine has also loaded the data bytes and the port/attribute byte with the result.

All host reads are registered: the byte at `host_addr` appears on `host_rdata` one clock later.

Top module: `mac_tbl_engine`

## Requirements
- R1: After reset every register reads 0. Bit 0 of the control byte at 0x70 is the busy flag. It rises on the clock edge that accepts a command and falls on the edge that stores the result code in bits [6:5] of 0x70.
- R2: A host write to 0x70 while busy is low starts a command. Bits [4:3] select the operation: 00 search, 01 write, 10 read, 11 delete. Bits [2:1] select the table: 00 unicast, 01 multicast. These bits read back unchanged from bits [4:1].
- R3: A table code of 10 or 11 completes after one busy cycle with result 11 (bad command) and leaves both tables unchanged.
- R4: A write whose key is not already in the table stores the key from 0x71..0x76 (0x71 is the least significant byte) in the lowest-numbered free slot and returns result 00. It also stores the port value from bits [3:0] of 0x77, the static flag from bit 4 and the override flag from bit 6.
- R5: A write whose key is already valid in the table replaces that entry's port value and attributes in place, without taking another slot.
- R6: A write of a new key into a table whose slots are all valid returns result 10 (table full).
- R7: A search hit returns result 00. It loads the entry index into 0x71, clears 0x72..0x76, and loads the stored port value and attributes into 0x77.
- R8: A search or delete that finds no valid entry with the key returns result 01 and leaves the data and port/attribute bytes unchanged.
- R9: A delete hit returns result 00 and frees the entry. A later search for that key misses, and the freed slot is the first one reused by the next write.
- R10: A read takes the index from 0x71..0x76. If the index is below the table size and the slot is valid, it returns result 00, loads the entry's key into 0x71..0x76 and its port value and attributes into 0x77. Otherwise it returns result 01.
- R11: The multicast table is separate from the unicast table and returns a port bitmap in 0x77 bits [3:0]. Its static flag (bit 4) is always stored as 0, and its bit 5 reads 0.
- R12: While busy is high, host writes to 0x70..0x77 are ignored, so a second command is dropped and the data bytes keep their values.
- R13: The search, delete and write scans check one slot per clock. A hit at index i keeps busy high for i+1 cycles, and a scan that reaches the last slot keeps it high for one cycle per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 8 | Register byte address (0x70..0x77) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for host_addr |

## Verification
On every cycle the assertions check the following. A command write accepted while idle raises busy. Busy never rises without such a write. Busy never lasts longer than one cycle per slot. A bad table code always ends with result 11. The number of valid entries changes by at most one per cycle. The returned payloads and the index reported after a hit can only be shown by the bench's scenarios. So can the lowest-free-slot choice, in-place update, full-table detection, the multicast attribute masking and the drop of writes during busy, all observed through the register bytes.

// File: rtl/mte_pkg.sv
package mte_pkg;
  typedef enum logic [1:0] {OP_SEARCH = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_DELETE = 2'd3} op_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_MISS = 2'd1, ST_FULL = 2'd2, ST_BADCMD = 2'd3} st_e;
  localparam logic [7:0] REG_CTRL = 8'h70;
  localparam logic [7:0] REG_D0   = 8'h71;
  localparam logic [7:0] REG_PA   = 8'h77;
  localparam int ATTR_W = 3;
endpackage

// File: rtl/mte_table.sv
module mte_table #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 48,
  parameter int PA_W    = 7,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               clr,
  input  logic [AW-1:0]      widx,
  input  logic [KEY_W-1:0]   wkey,
  input  logic [PA_W-1:0]    wpa,
  input  logic [AW-1:0]      ridx,
  output logic               rvalid,
  output logic [KEY_W-1:0]   rkey,
  output logic [PA_W-1:0]    rpa,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [KEY_W-1:0] key_mem [ENTRIES];
  logic [PA_W-1:0]  pa_mem  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (we) begin
      key_mem[widx] <= wkey;
      pa_mem[widx]  <= wpa;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[widx] <= 1'b1;
    else if (clr) valid_q[widx] <= 1'b0;
  end

  assign rvalid    = valid_q[ridx];
  assign rkey      = key_mem[ridx];
  assign rpa       = pa_mem[ridx];
  assign valid_vec = valid_q;
endmodule

// File: rtl/mte_seq.sv
module mte_seq import mte_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 48,
  parameter int PORT_W  = 4,
  localparam int AW     = $clog2(ENTRIES),
  localparam int PA_W   = PORT_W + ATTR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       start_op,
  input  logic [1:0]       start_tbl,
  input  logic [KEY_W-1:0] start_key,
  input  logic [PA_W-1:0]  start_pa,
  input  logic             rvalid,
  input  logic [KEY_W-1:0] rkey,
  input  logic [PA_W-1:0]  rpa,
  output logic [AW-1:0]    ridx,
  output logic             tsel,
  output logic             we,
  output logic             clr,
  output logic [AW-1:0]    widx,
  output logic [KEY_W-1:0] wkey,
  output logic [PA_W-1:0]  wpa,
  output logic             busy,
  output logic             done,
  output logic [1:0]       st_nxt,
  output logic             ld_key,
  output logic [KEY_W-1:0] ld_key_val,
  output logic             ld_pa,
  output logic [PA_W-1:0]  ld_pa_val
);
  logic             run_q;
  op_e              op_q;
  logic [1:0]       tbl_q;
  logic [KEY_W-1:0] key_q;
  logic [PA_W-1:0]  pa_q;
  logic [AW-1:0]    ptr_q, free_idx_q;
  logic             free_q;
  logic             hit, last;

  assign busy = run_q;
  assign tsel = tbl_q[0];
  assign wkey = key_q;
  // static flag only kept for unicast; signature bit always written 0
  assign wpa  = {pa_q[PA_W-1], 1'b0, (tbl_q[0] ? 1'b0 : pa_q[PORT_W]), pa_q[PORT_W-1:0]};

  always_comb begin
    ridx       = (op_q == OP_READ) ? key_q[AW-1:0] : ptr_q;
    hit        = rvalid && (rkey == key_q);
    last       = (ptr_q == AW'(ENTRIES - 1));
    done       = 1'b0;
    st_nxt     = ST_OK;
    we         = 1'b0;
    clr        = 1'b0;
    widx       = ptr_q;
    ld_key     = 1'b0;
    ld_key_val = KEY_W'(ptr_q);
    ld_pa      = 1'b0;
    ld_pa_val  = rpa;
    if (run_q) begin
      if (tbl_q[1]) begin
        done   = 1'b1;
        st_nxt = ST_BADCMD;
      end else begin
        unique case (op_q)
          OP_SEARCH: begin
            if (hit) begin
              done = 1'b1; ld_key = 1'b1; ld_pa = 1'b1;
            end else if (last) begin
              done = 1'b1; st_nxt = ST_MISS;
            end
          end
          OP_DELETE: begin
            if (hit) begin
              done = 1'b1; clr = 1'b1;
            end else if (last) begin
              done = 1'b1; st_nxt = ST_MISS;
            end
          end
          OP_READ: begin
            done = 1'b1;
            if (key_q < KEY_W'(ENTRIES) && rvalid) begin
              ld_key = 1'b1; ld_key_val = rkey; ld_pa = 1'b1;
            end else begin
              st_nxt = ST_MISS;
            end
          end
          OP_WRITE: begin
            if (hit) begin
              done = 1'b1; we = 1'b1;
            end else if (last) begin
              done = 1'b1;
              if (free_q) begin
                we = 1'b1; widx = free_idx_q;
              end else if (!rvalid) begin
                we = 1'b1;
              end else begin
                st_nxt = ST_FULL;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      op_q       <= OP_SEARCH;
      tbl_q      <= '0;
      key_q      <= '0;
      pa_q       <= '0;
      ptr_q      <= '0;
      free_idx_q <= '0;
      free_q     <= 1'b0;
    end else if (!run_q) begin
      if (start) begin
        run_q  <= 1'b1;
        op_q   <= op_e'(start_op);
        tbl_q  <= start_tbl;
        key_q  <= start_key;
        pa_q   <= start_pa;
        ptr_q  <= '0;
        free_q <= 1'b0;
      end
    end else if (done) begin
      run_q <= 1'b0;
    end else begin
      ptr_q <= ptr_q + 1'b1;
      if (op_q == OP_WRITE && !rvalid && !free_q) begin
        free_q     <= 1'b1;
        free_idx_q <= ptr_q;
      end
    end
  end
endmodule

// File: rtl/mac_tbl_engine.sv
module mac_tbl_engine import mte_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 48,
  parameter int PORT_W  = 4,
  localparam int AW        = $clog2(ENTRIES),
  localparam int PA_W      = PORT_W + ATTR_W,
  localparam int KEY_BYTES = KEY_W / 8,
  localparam int NTBL      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  logic [KEY_W-1:0] key_r;
  logic [PA_W-1:0]  pa_r;
  logic [3:0]       cmd_r;
  logic [1:0]       st_r;
  logic [7:0]       rd_mux;

  logic             busy, done, start, wr_ok;
  logic [1:0]       st_nxt;
  logic             ld_key, ld_pa;
  logic [KEY_W-1:0] ld_key_val;
  logic [PA_W-1:0]  ld_pa_val;
  logic [AW-1:0]    ridx, widx;
  logic             tsel, s_we, s_clr;
  logic [KEY_W-1:0] wkey;
  logic [PA_W-1:0]  wpa;

  logic             t_rvalid [NTBL];
  logic [KEY_W-1:0] t_rkey   [NTBL];
  logic [PA_W-1:0]  t_rpa    [NTBL];
  logic [NTBL*ENTRIES-1:0] valid_all;

  assign wr_ok = host_wr && !busy;
  assign start = wr_ok && (host_addr == REG_CTRL);

  mte_seq #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .PORT_W(PORT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .start_op(host_wdata[4:3]), .start_tbl(host_wdata[2:1]),
    .start_key(key_r), .start_pa(pa_r),
    .rvalid(t_rvalid[tsel]), .rkey(t_rkey[tsel]), .rpa(t_rpa[tsel]),
    .ridx(ridx), .tsel(tsel), .we(s_we), .clr(s_clr), .widx(widx),
    .wkey(wkey), .wpa(wpa), .busy(busy), .done(done), .st_nxt(st_nxt),
    .ld_key(ld_key), .ld_key_val(ld_key_val), .ld_pa(ld_pa), .ld_pa_val(ld_pa_val)
  );

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    mte_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .PA_W(PA_W)) u_tbl (
      .clk(clk), .rst(rst),
      .we(s_we && (tsel == t[0])), .clr(s_clr && (tsel == t[0])),
      .widx(widx), .wkey(wkey), .wpa(wpa), .ridx(ridx),
      .rvalid(t_rvalid[t]), .rkey(t_rkey[t]), .rpa(t_rpa[t]),
      .valid_vec(valid_all[t*ENTRIES +: ENTRIES])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_r <= '0;
      pa_r  <= '0;
      cmd_r <= '0;
      st_r  <= '0;
    end else begin
      if (wr_ok) begin
        if (host_addr == REG_CTRL) cmd_r <= host_wdata[4:1];
        if (host_addr == REG_PA) pa_r <= host_wdata[PA_W-1:0];
        for (int i = 0; i < KEY_BYTES; i++)
          if (host_addr == 8'(REG_D0 + i)) key_r[8*i +: 8] <= host_wdata;
      end
      if (ld_key) key_r <= ld_key_val;
      if (ld_pa)  pa_r  <= ld_pa_val;
      if (done)   st_r  <= st_nxt;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr == REG_CTRL) rd_mux = {1'b0, st_r, cmd_r, busy};
    if (host_addr == REG_PA)   rd_mux = 8'(pa_r);
    for (int i = 0; i < KEY_BYTES; i++)
      if (host_addr == 8'(REG_D0 + i)) rd_mux = key_r[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else host_rdata <= rd_mux;
  end
endmodule

// File: rtl/mte_checker.sv
module mte_checker import mte_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int CW = $clog2(ENTRIES) + 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   host_wr,
  input logic [7:0]             host_addr,
  input logic                   busy,
  input logic [1:0]             tbl_code,
  input logic [1:0]             status,
  input logic [2*ENTRIES-1:0]   valid_all
);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
  end

  p_cmd_starts_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && host_wr && host_addr == REG_CTRL) |=> busy);

  p_busy_source_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(host_wr && host_addr == REG_CTRL));

  p_busy_bound_r13: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < CW'(ENTRIES)));

  p_badtbl_status_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && tbl_code[1]) |-> (status == ST_BADCMD));

  p_valid_step_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(valid_all) <= $past($countones(valid_all)) + 1) &&
    ($countones(valid_all) + 1 >= $past($countones(valid_all))));
endmodule

bind mac_tbl_engine mte_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .busy(busy), .tbl_code(cmd_r[1:0]), .status(st_r), .valid_all(valid_all)
);

// File: tb/mac_tbl_engine_test.sv
`timescale 1ns/1ps
module mac_tbl_engine_test;
  localparam int ENT = 16;
  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h00AA_BBCC_DDEE;
  localparam logic [47:0] MAC_C = 48'h0102_0304_0506;
  localparam logic [47:0] MAC_Z = 48'hDEAD_BEEF_0001;

  typedef struct packed {
    logic [1:0] op; logic [1:0] tbl; logic [47:0] mac; logic [7:0] pa;
    logic [1:0] st; logic chk; logic [7:0] exp_pa; logic [3:0] idx;
  } vec_t;

  // op: 0 search 1 write 2 read 3 delete; st: 0 ok 1 miss 2 full 3 bad
  localparam logic [74:0] VEC [16] = '{
    {2'd1, 2'd0, MAC_A, 8'h13, 2'd0, 1'b0, 8'h00, 4'd0},  // R4 slot 0
    {2'd1, 2'd0, MAC_B, 8'h45, 2'd0, 1'b0, 8'h00, 4'd0},  // R4 slot 1
    {2'd0, 2'd0, MAC_A, 8'h00, 2'd0, 1'b1, 8'h13, 4'd0},  // R7
    {2'd0, 2'd0, MAC_B, 8'h00, 2'd0, 1'b1, 8'h45, 4'd1},  // R7
    {2'd0, 2'd0, MAC_C, 8'h00, 2'd1, 1'b0, 8'h00, 4'd0},  // R8
    {2'd1, 2'd0, MAC_A, 8'h07, 2'd0, 1'b0, 8'h00, 4'd0},  // R5
    {2'd0, 2'd0, MAC_A, 8'h00, 2'd0, 1'b1, 8'h07, 4'd0},  // R5
    {2'd3, 2'd0, MAC_C, 8'h00, 2'd1, 1'b0, 8'h00, 4'd0},  // R8
    {2'd3, 2'd0, MAC_A, 8'h00, 2'd0, 1'b0, 8'h00, 4'd0},  // R9
    {2'd0, 2'd0, MAC_A, 8'h00, 2'd1, 1'b0, 8'h00, 4'd0},  // R9
    {2'd1, 2'd0, MAC_C, 8'h02, 2'd0, 1'b0, 8'h00, 4'd0},  // R9
    {2'd0, 2'd0, MAC_C, 8'h00, 2'd0, 1'b1, 8'h02, 4'd0},  // R9 freed slot reused
    {2'd1, 2'd1, MAC_A, 8'h5A, 2'd0, 1'b0, 8'h00, 4'd0},  // R11
    {2'd0, 2'd1, MAC_A, 8'h00, 2'd0, 1'b1, 8'h4A, 4'd0},  // R11
    {2'd0, 2'd0, MAC_A, 8'h00, 2'd1, 1'b0, 8'h00, 4'd0},  // R11 tables separate
    {2'd0, 2'd2, MAC_A, 8'h00, 2'd3, 1'b0, 8'h00, 4'd0}   // R3
  };

  logic clk = 1'b0, rst = 1'b1, host_wr = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00, host_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mac_tbl_engine uut (.clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
                      .host_wdata(host_wdata), .host_rdata(host_rdata));

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    int n = 0;
    rd(8'h70, c);
    while (c[0] && n < 500) begin rd(8'h70, c); n++; end
    if (c[0]) check("R13 busy stuck", 48'(c[0]), 48'h0);
  endtask

  task automatic load_key(input logic [47:0] k);
    for (int i = 0; i < 6; i++) wr(8'(8'h71 + i), k[8*i +: 8]);
  endtask

  task automatic read_key(output logic [47:0] k);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin rd(8'(8'h71 + i), b); k[8*i +: 8] = b; end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [1:0] tbl, input logic [47:0] k,
                         input logic [7:0] pa, output logic [1:0] st);
    logic [7:0] c;
    wait_idle();
    load_key(k);
    wr(8'h77, pa);
    wr(8'h70, {3'b000, op, tbl, 1'b0});
    wait_idle();
    rd(8'h70, c);
    st = c[6:5];
  endtask

  task automatic count_busy(input logic [47:0] k, output int cnt);
    wait_idle();
    load_key(k);
    wr(8'h70, 8'h00);          // search, unicast; host_addr stays at 0x70
    cnt = 0;
    @(negedge clk);
    while (host_rdata[0] && cnt < 100) begin cnt++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [1:0] st;
    logic [47:0] k;
    int cnt;
    vec_t v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 8'h70; a <= 8'h77; a++) begin
      rd(8'(a), b);
      check("R1 reset value", 48'(b), 48'h0);
    end

    // vector walk: R2 R3 R4 R5 R7 R8 R9 R11
    for (int i = 0; i < 16; i++) begin
      v = VEC[i];
      run_cmd(v.op, v.tbl, v.mac, v.pa, st);
      check($sformatf("R2 vector %0d status", i), 48'(st), 48'(v.st));
      rd(8'h70, b);
      check($sformatf("R2 vector %0d cmd field", i), 48'(b[4:1]), 48'({v.op, v.tbl}));
      if (v.chk) begin
        rd(8'h77, b);
        check($sformatf("R7 vector %0d port/attr", i), 48'(b), 48'(v.exp_pa));
        rd(8'h71, b);
        check($sformatf("R7 vector %0d index", i), 48'(b), 48'(v.idx));
        rd(8'h72, b);
        check($sformatf("R7 vector %0d index high", i), 48'(b), 48'h0);
      end
    end

    // R10 read by index
    run_cmd(2'd2, 2'd0, 48'd1, 8'h00, st);
    check("R10 read ok status", 48'(st), 48'd0);
    read_key(k);
    check("R10 read key", k, MAC_B);
    rd(8'h77, b);
    check("R10 read port/attr", 48'(b), 48'h45);
    run_cmd(2'd2, 2'd0, 48'd5, 8'h00, st);
    check("R10 read empty slot", 48'(st), 48'd1);
    run_cmd(2'd2, 2'd0, 48'h0000_0000_0100, 8'h00, st);
    check("R10 read index out of range", 48'(st), 48'd1);

    // R13 busy length: miss scans every slot, hit at index 1 takes 2 cycles
    count_busy(MAC_Z, cnt);
    check("R13 busy on miss", 48'(cnt), 48'(ENT));
    count_busy(MAC_B, cnt);
    check("R13 busy on hit idx1", 48'(cnt), 48'd2);

    // R12 writes and a second command during busy are dropped
    wait_idle();
    load_key(MAC_Z);
    wr(8'h70, 8'h00);
    wr(8'h71, 8'hEE);
    wr(8'h70, 8'h08);          // write, unicast: must be dropped
    wait_idle();
    rd(8'h71, b);
    check("R12 data byte kept", 48'(b), 48'(MAC_Z[7:0]));
    rd(8'h70, b);
    check("R12 no second command", 48'(b[0]), 48'h0);
    run_cmd(2'd0, 2'd0, MAC_Z, 8'h00, st);
    check("R12 dropped write left no entry", 48'(st), 48'd1);

    // R6 fill multicast table (slot 0 already used) then overflow
    for (int j = 1; j < ENT; j++) begin
      run_cmd(2'd1, 2'd1, 48'h0100_0000_0000 + 48'(j), 8'h03, st);
      if (st !== 2'd0) check("R6 fill status", 48'(st), 48'd0);
    end
    run_cmd(2'd1, 2'd1, MAC_Z, 8'h01, st);
    check("R6 table full", 48'(st), 48'd2);
    run_cmd(2'd1, 2'd1, MAC_A, 8'h0C, st);
    check("R5 update in full table", 48'(st), 48'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule